// File: doc/BRIEF.md
# Logic-Tile Clock Enable Generator

This block produces one clock-enable strobe for each of six configurable-logic tile instances, all inside a single system clock domain. One 32-bit control register, written and read through a plain register port, sets two cascaded divider stages and one mode bit per instance. The first stage divides by 1 to 8 and the second by 1 or 2.

An instance whose mode bit is clear runs in step with the peripheral clock. Its enable is the incoming peripheral-clock enable, unchanged. An instance whose mode bit is set takes the divided strobe instead. That strobe is a one-cycle pulse that fires once every (main+1)·(tile+1) system clocks.

A small state machine runs the divider counters. It has two states:
- **SETTLE** is entered on reset and on every register write. Its counters are held at zero and it gives no pulse.
- **RUN** is where the counters advance and the pulse is produced.

The transitions are:
- *settle_done*: SETTLE to RUN, taken unconditionally after one cycle.
- *run_hold*: RUN to RUN, taken while no write arrives.
- *restart*: from either state back to SETTLE, taken on any write.

Top module: `tcg_top`

## Requirements
- R1: After reset the register reads 0x0000_0007: main divider code 7 (/8), tile bit 0, and all mode bits 0.
- R2: With tile bit (bit 4) at 0, main divider code n in bits 2:0 makes every divided instance give exactly one enable pulse per n+1 system clocks.
- R3: With tile bit (bit 4) at 1, the period of the divided pulse is 2·(n+1) system clocks.
- R4: Bit 16+i is the mode bit of instance i, for i from 0 to 5. A 1 selects the divided pulse and a 0 selects the peripheral-clock enable.
- R5: The enable of a synchronous instance equals pclk_en in every cycle, whatever the divider fields hold.
- R6: Bits 3, 15:5 and 31:22 always read 0, and writes to them are ignored. The writable bits read back what was last written.
- R7: Any write restarts the dividers. The divided pulse is low for the N cycles that follow the write edge and is high in cycle N+1, where N is the new period.
- R8: When the period is above 1, each divided pulse is a single cycle wide and no two pulses are adjacent.
- R9: Asserting rst_n at any time returns every field to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register contents |
| pclk_en | input | 1 | Peripheral-clock enable from the system clock domain |
| inst_ce | output | 6 | Per-instance clock enables, bit i for instance i |

## Verification
The assertions treat wr_en and wr_data as synchronous to clk and stable around the rising edge. They also assume that reset is the only thing that can disturb the counters apart from a write. The bench changes every input on the falling edge and pulses wr_en for exactly one cycle, so each write is a single clean restart. pclk_en is toggled from the bench on rising edges with nonblocking updates, which keeps it a legal single-domain enable.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
    localparam int REG_W    = 32;
    localparam int MAIN_W   = 3;
    localparam int TILE_W   = 1;
    localparam int N_INST   = 6;
    localparam int MAIN_LSB = 0;
    localparam int TILE_LSB = 4;
    localparam int MODE_LSB = 16;

    typedef enum logic [0:0] {
        ST_SETTLE = 1'b0,
        ST_RUN    = 1'b1
    } div_state_e;
endpackage

// File: rtl/tcg_ctrl_reg.sv
module tcg_ctrl_reg
    import tcg_pkg::*;
#(
    parameter int MAIN_BITS = MAIN_W,
    parameter int TILE_BITS = TILE_W,
    parameter int INSTS     = N_INST
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic [MAIN_BITS-1:0] main_div,
    output logic [TILE_BITS-1:0] tile_div,
    output logic [INSTS-1:0]     mode_div
);
    localparam logic [REG_W-1:0] MAIN_MASK = REG_W'((64'd1 << MAIN_BITS) - 64'd1) << MAIN_LSB;
    localparam logic [REG_W-1:0] TILE_MASK = REG_W'((64'd1 << TILE_BITS) - 64'd1) << TILE_LSB;
    localparam logic [REG_W-1:0] MODE_MASK = REG_W'((64'd1 << INSTS) - 64'd1) << MODE_LSB;
    localparam logic [REG_W-1:0] RW_MASK   = MAIN_MASK | TILE_MASK | MODE_MASK;
    localparam logic [REG_W-1:0] RST_VAL   = MAIN_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_div <= '1;
            tile_div <= '0;
            mode_div <= '0;
        end else if (wr_en) begin
            main_div <= wr_data[MAIN_LSB +: MAIN_BITS];
            tile_div <= wr_data[TILE_LSB +: TILE_BITS];
            mode_div <= wr_data[MODE_LSB +: INSTS];
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[MAIN_LSB +: MAIN_BITS] = main_div;
        rd_data[TILE_LSB +: TILE_BITS] = tile_div;
        rd_data[MODE_LSB +: INSTS]     = mode_div;
    end

    // R6: written value returns with unused bits cleared
    assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == ($past(wr_data) & RW_MASK)));

    // R1: first cycle out of reset shows the reset value
    assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == RST_VAL));
endmodule

// File: rtl/tcg_div_fsm.sv
module tcg_div_fsm
    import tcg_pkg::*;
#(
    parameter int MAIN_BITS = MAIN_W,
    parameter int TILE_BITS = TILE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic [MAIN_BITS-1:0] main_div,
    input  logic [TILE_BITS-1:0] tile_div,
    output logic                 div_pulse
);
    div_state_e             state, state_nxt;
    logic [MAIN_BITS-1:0]   main_cnt;
    logic [TILE_BITS-1:0]   tile_cnt;
    logic                   main_wrap;
    logic                   tile_wrap;

    assign main_wrap = (main_cnt == main_div);
    assign tile_wrap = (tile_cnt == tile_div);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SETTLE: state_nxt = ST_RUN;   // settle_done
            ST_RUN:    state_nxt = ST_RUN;   // run_hold
        endcase
        if (restart) state_nxt = ST_SETTLE;  // restart
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SETTLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_cnt <= '0;
            tile_cnt <= '0;
        end else if (restart || state == ST_SETTLE) begin
            main_cnt <= '0;
            tile_cnt <= '0;
        end else if (main_wrap) begin
            main_cnt <= '0;
            tile_cnt <= tile_wrap ? '0 : tile_cnt + 1'b1;
        end else begin
            main_cnt <= main_cnt + 1'b1;
        end
    end

    always_comb begin
        div_pulse = 1'b0;
        unique case (state)
            ST_SETTLE: div_pulse = 1'b0;
            ST_RUN:    div_pulse = main_wrap && tile_wrap;
        endcase
    end

    // R2: the main counter never passes its terminal count
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        main_cnt <= main_div);

    // R7: a write is followed by a pulse-free settle cycle
    assert_settle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !div_pulse);

    // R8: pulses are isolated whenever the period exceeds one
    assert_pulse_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && !restart && (main_div != '0 || tile_div != '0)) |=> !div_pulse);
endmodule

// File: rtl/tcg_ce_mux.sv
module tcg_ce_mux (
    input  logic sel_div,
    input  logic div_pulse,
    input  logic pclk_en,
    output logic ce
);
    always_comb begin
        ce = sel_div ? div_pulse : pclk_en;
    end
endmodule

// File: rtl/tcg_top.sv
module tcg_top
    import tcg_pkg::*;
#(
    parameter int MAIN_BITS = MAIN_W,
    parameter int TILE_BITS = TILE_W,
    parameter int INSTS     = N_INST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             pclk_en,
    output logic [INSTS-1:0] inst_ce
);
    logic [MAIN_BITS-1:0] main_div;
    logic [TILE_BITS-1:0] tile_div;
    logic [INSTS-1:0]     mode_div;
    logic                 div_pulse;

    tcg_ctrl_reg #(
        .MAIN_BITS(MAIN_BITS), .TILE_BITS(TILE_BITS), .INSTS(INSTS)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .main_div(main_div), .tile_div(tile_div),
        .mode_div(mode_div)
    );

    tcg_div_fsm #(
        .MAIN_BITS(MAIN_BITS), .TILE_BITS(TILE_BITS)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .restart(wr_en),
        .main_div(main_div), .tile_div(tile_div), .div_pulse(div_pulse)
    );

    for (genvar i = 0; i < INSTS; i++) begin : g_inst
        tcg_ce_mux u_mux (
            .sel_div(mode_div[i]), .div_pulse(div_pulse),
            .pclk_en(pclk_en), .ce(inst_ce[i])
        );
    end

    // R5: a synchronous instance never strobes without a peripheral enable
    assert_sync_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_div[0] && !pclk_en) |-> !inst_ce[0]);
endmodule

// File: tb/tb_tcg_top.sv
module tb_tcg_top;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pclk_en = 1'b0;
    logic [NI-1:0] inst_ce;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    tcg_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pclk_en(pclk_en), .inst_ce(inst_ce)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            pclk_en <= rst_n ? ~pclk_en : 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // R1: reset contents
    task automatic t_reset();
        @(negedge clk);
        check(rd_data == 32'h7, "R1 reset value", rd_data, 32'h7);
    endtask

    // R6: unused bits read zero, writable bits read back
    task automatic t_reserved();
        reg_write(32'hFFFF_FFFF);
        check(rd_data == 32'h003F_0017, "R6 all-ones write", rd_data, 32'h003F_0017);
        reg_write(32'hA5C0_FFE8);
        check(rd_data == 32'h0000_0000, "R6 reserved-only write", rd_data, 0);
        reg_write(32'h002A_0005);
        check(rd_data == 32'h002A_0005, "R6 writable readback", rd_data, 32'h002A_0005);
    endtask

    // R2 R3 R8: every code with all instances divided
    task automatic t_div_sweep();
        for (int t = 0; t < 2; t++) begin
            for (int m = 0; m < 8; m++) begin
                int per = (m + 1) * (t + 1);
                int win = 4 * per;
                int cnt [NI];
                int adj = 0;
                logic [NI-1:0] prev = '0;
                reg_write(32'h003F_0000 | (t << 4) | m);
                repeat (2) @(negedge clk);
                for (int i = 0; i < NI; i++) cnt[i] = 0;
                for (int c = 0; c < win; c++) begin
                    @(negedge clk);
                    for (int i = 0; i < NI; i++) begin
                        if (inst_ce[i]) cnt[i]++;
                        if (inst_ce[i] && prev[i] && per > 1) adj++;
                    end
                    prev = inst_ce;
                end
                for (int i = 0; i < NI; i++) begin
                    if (t == 0) check(cnt[i] == 4, "R2 pulse count /(n+1)", cnt[i], 4);
                    else        check(cnt[i] == 4, "R3 pulse count tile x2", cnt[i], 4);
                end
                check(adj == 0, "R8 adjacent pulses", adj, 0);
            end
        end
    endtask

    // R5: synchronous instances follow pclk_en whatever the dividers hold
    task automatic t_sync();
        for (int m = 0; m < 8; m += 3) begin
            int mism = 0;
            int cnt = 0;
            reg_write(32'h0000_0010 | m);
            repeat (2) @(negedge clk);
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (inst_ce != {NI{pclk_en}}) mism++;
                if (inst_ce[3]) cnt++;
            end
            check(mism == 0, "R5 sync mismatch cycles", mism, 0);
            check(cnt == 10, "R5 sync enable count", cnt, 10);
        end
    endtask

    // R4: bit 16+i maps to instance i
    task automatic t_mixed();
        int cnt [NI];
        reg_write(32'h0015_0002);
        repeat (2) @(negedge clk);
        for (int i = 0; i < NI; i++) cnt[i] = 0;
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            for (int i = 0; i < NI; i++) if (inst_ce[i]) cnt[i]++;
        end
        for (int i = 0; i < NI; i++) begin
            int exp = (i % 2 == 0) ? 8 : 12;
            check(cnt[i] == exp, "R4 per-instance mode", cnt[i], exp);
        end
    endtask

    // R7: restart timing after a write
    task automatic t_restart();
        int per = 6;
        int early = 0;
        reg_write(32'h0000_0007);
        repeat (3) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 32'h0001_0012;
        @(negedge clk);
        wr_en = 1'b0;
        if (inst_ce[0]) early++;
        for (int k = 2; k <= per; k++) begin
            @(negedge clk);
            if (inst_ce[0]) early++;
        end
        check(early == 0, "R7 pulse before full period", early, 0);
        @(negedge clk);
        check(inst_ce[0] == 1'b1, "R7 first pulse cycle", inst_ce[0], 1);
    endtask

    // R9: reset in the middle of operation
    task automatic t_reset_mid();
        reg_write(32'h003F_0013);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(rd_data == 32'h7, "R9 reset during run", rd_data, 32'h7);
        check(inst_ce == '0, "R9 enables in reset", inst_ce, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 32'h7, "R9 value after release", rd_data, 32'h7);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reserved();
        t_div_sweep();
        t_sync();
        t_mixed();
        t_restart();
        t_reset_mid();
        finish_run();
    end
endmodule